// File: doc/BRIEF.md
# Stepped Digital Sample Gain with Mute and Zero-Run Detection

This block scales one channel of 16-bit two's-complement audio by a gain picked from a small code in fixed 1.5 dB steps. It is built in one of two flavours, chosen by a parameter. The boost flavour sits on the record path and takes a 4-bit code that lifts the level by up to +22.5 dB. The cut flavour sits on the playback path and takes a 5-bit code that lowers the level by up to -46.5 dB. A stereo path uses one instance per channel.

A mute input forces the output to silence whatever the code is. Any product beyond the 16-bit range is clipped to the exact full-scale code of that sign. On the playback flavour, an optional detector watches for long runs of all-zero input samples. Once a run is long enough it raises a zero-mute flag, which downstream logic uses to silence the converter. The first nonzero sample drops the flag again.

Each sample arrives with a valid strobe. Its scaled result and a matching valid flag appear one clock later.

Top module: `audio_step_gain`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high, and low otherwise.
- R2: In boost mode (`CUT_MODE`=0, 4-bit `gain_code` k = 0..15) an unmuted sample x yields round(x·10^(1.5k/20)), within 1 LSB.
- R3: In cut mode (`CUT_MODE`=1, 5-bit `gain_code` k = 0..31) an unmuted sample x yields round(x·10^(-1.5k/20)), within 1 LSB.
- R4: While `mute` is high on a valid sample, the result for that sample is 16'h0000 for every gain code.
- R5: A result above +32767 is output as 16'h7FFF, and one below -32768 is output as 16'h8000. Bit 15 is the sign (MSB) and bit 0 the LSB.
- R6: In a cycle after one with `in_valid` low, `out_sample` and `zero_mute` keep their values.
- R7: Gain code 0 without mute passes the sample through unchanged, bit for bit.
- R8: With zero detection on, `zero_mute` rises with the result of the `ZRUN_LEN`-th consecutive valid all-zero sample and stays high while valid zero samples continue. Cycles with `in_valid` low do not break a run.
- R9: A valid nonzero sample clears `zero_mute` with its own result and restarts the run count. A run shorter than `ZRUN_LEN` does not raise the flag.
- R10: While `rst_n` is low at a clock edge, `out_valid`, `out_sample` and `zero_mute` become 0.
- R11: With zero detection off (`ZDET_EN`=0), `zero_mute` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | SAMPLE_W | Two's-complement input sample |
| gain_code | input | CODE_W | Step count: boost steps (4 bits) or cut steps (5 bits) |
| mute | input | 1 | Forces silence for the sample presented with it |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_sample | output | SAMPLE_W | Scaled, rounded and clipped result |
| zero_mute | output | 1 | Long run of zero input samples detected |

## Verification
The bench builds two instances from the same stimulus. One is the cut flavour with zero detection on and `ZRUN_LEN` lowered to 16, so that engaging, holding across idle cycles, releasing, and a run one sample too short all fit in a few hundred cycles. The other is the boost flavour with detection off. Both use the default 16 fractional coefficient bits, and every code is swept against a real-valued gain law. The boost sweep drives full-scale samples, which makes both clip codes reachable, and small samples, which exercise rounding near zero.

// File: rtl/audio_gain_pkg.sv
// Package: shared constants and the coefficient generator for the gain stage.
// Assumes coefficients are unsigned fixed point with a caller-chosen number
// of fractional bits. Coefficients are computed at elaboration only.
package audio_gain_pkg;

    // Linear ratio of one 1.5 dB step, 10^(1.5/20)
    localparam real STEP_RATIO = 1.1885022274370185;

    // Coefficient for a given step count, rounded to nearest
    function automatic longint step_coef(input int code, input bit cut, input int frac);
        real r;
        r = 1.0;
        for (int i = 0; i < code; i++) begin
            r = cut ? (r / STEP_RATIO) : (r * STEP_RATIO);
        end
        return longint'($rtoi(r * real'(longint'(1) << frac) + 0.5));
    endfunction

endpackage

// File: rtl/gain_coef_rom.sv
// Module: gain_coef_rom
// Maps a gain code to its fixed-point coefficient. The table is built by a
// generate loop from the step law at elaboration time, one entry per code.
// Assumes COEF_W is wide enough for the largest coefficient of the flavour.
module gain_coef_rom #(
    parameter int CUT_MODE = 0,
    parameter int CODE_W   = 4,
    parameter int COEF_W   = 20,
    parameter int FRAC_W   = 16
) (
    input  logic [CODE_W-1:0] code,
    output logic [COEF_W-1:0] coef
);
    localparam int NUM_CODES = 1 << CODE_W;

    logic [COEF_W-1:0] tab [NUM_CODES];

    // Constant table entry for each code
    for (genvar g = 0; g < NUM_CODES; g++) begin : g_tab
        localparam longint CVAL = audio_gain_pkg::step_coef(g, CUT_MODE != 0, FRAC_W);
        assign tab[g] = COEF_W'(CVAL);
    end

    // Table lookup
    assign coef = tab[code];

endmodule

// File: rtl/gain_mult_clip.sv
// Module: gain_mult_clip
// Combinational multiply of a signed sample by an unsigned coefficient. The
// product is rounded half-up, clipped to the sample range, and forced to zero
// under mute. Assumes FRAC_W >= 1.
module gain_mult_clip #(
    parameter int SAMPLE_W = 16,
    parameter int COEF_W   = 20,
    parameter int FRAC_W   = 16
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [COEF_W-1:0]   coef,
    input  logic                mute,
    output logic [SAMPLE_W-1:0] result
);
    localparam int PROD_W = SAMPLE_W + COEF_W + 1;
    localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) <<< (FRAC_W - 1);
    localparam logic signed [PROD_W-1:0] MAXV = PROD_W'((1 << (SAMPLE_W - 1)) - 1);
    localparam logic signed [PROD_W-1:0] MINV = -PROD_W'(1 << (SAMPLE_W - 1));
    localparam logic [SAMPLE_W-1:0] POS_FS = {1'b0, {(SAMPLE_W-1){1'b1}}};
    localparam logic [SAMPLE_W-1:0] NEG_FS = {1'b1, {(SAMPLE_W-1){1'b0}}};

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] rnd_sum;
    logic signed [PROD_W-1:0] rounded;

    // Full-precision product, rounding and clipping
    always_comb begin
        prod    = PROD_W'(signed'(sample)) * PROD_W'(signed'({1'b0, coef}));
        rnd_sum = prod + HALF;
        rounded = rnd_sum >>> FRAC_W;
        if (mute)                 result = '0;
        else if (rounded > MAXV)  result = POS_FS;
        else if (rounded < MINV)  result = NEG_FS;
        else                      result = rounded[SAMPLE_W-1:0];
    end

endmodule

// File: rtl/zero_run_detect.sv
// Module: zero_run_detect
// Counts consecutive valid all-zero samples and flags when the run reaches
// RUN_LEN. A valid nonzero sample clears the count and the flag. Cycles
// without a valid sample leave everything unchanged. Assumes RUN_LEN >= 1.
module zero_run_detect #(
    parameter int SAMPLE_W = 16,
    parameter int RUN_LEN  = 2048
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    output logic                zmute
);
    localparam int CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_LEN);

    logic [CNT_W-1:0] run_cnt;
    logic             is_zero;

    assign is_zero = (in_sample == '0);

    // Saturating run counter and flag, advanced only on valid samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            zmute   <= 1'b0;
        end else if (in_valid) begin
            if (is_zero) begin
                if (run_cnt != LIMIT) run_cnt <= run_cnt + 1'b1;
                zmute <= (run_cnt >= LIMIT - 1'b1);
            end else begin
                run_cnt <= '0;
                zmute   <= 1'b0;
            end
        end
    end

    // R9: a nonzero valid sample releases the flag
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_zero) |=> !zmute);

    // R6: the flag moves only on valid samples
    a_r6_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(zmute));

    // R8: the flag can only rise on a valid zero sample
    a_r8_rise_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && is_zero) |=> !$rose(zmute));

endmodule

// File: rtl/audio_step_gain.sv
// Module: audio_step_gain
// One channel of stepped digital gain. The coefficient ROM feeds the
// multiply/round/clip path, whose result is registered together with a valid
// flag one cycle after the input strobe. The cut flavour can also carry the
// zero-run detector. Assumes mute and gain_code are sampled with in_valid.
module audio_step_gain #(
    parameter int CUT_MODE = 0,
    parameter int SAMPLE_W = 16,
    parameter int CODE_W   = (CUT_MODE != 0) ? 5 : 4,
    parameter int FRAC_W   = 16,
    parameter int COEF_W   = 20,
    parameter int ZDET_EN  = 0,
    parameter int ZRUN_LEN = 2048
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic [CODE_W-1:0]   gain_code,
    input  logic                mute,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_sample,
    output logic                zero_mute
);
    localparam logic [SAMPLE_W-1:0] NEG_FS = {1'b1, {(SAMPLE_W-1){1'b0}}};

    logic [COEF_W-1:0]   coef;
    logic [SAMPLE_W-1:0] gained;

    gain_coef_rom #(
        .CUT_MODE (CUT_MODE),
        .CODE_W   (CODE_W),
        .COEF_W   (COEF_W),
        .FRAC_W   (FRAC_W)
    ) u_rom (
        .code (gain_code),
        .coef (coef)
    );

    gain_mult_clip #(
        .SAMPLE_W (SAMPLE_W),
        .COEF_W   (COEF_W),
        .FRAC_W   (FRAC_W)
    ) u_mul (
        .sample (in_sample),
        .coef   (coef),
        .mute   (mute),
        .result (gained)
    );

    // Output register: capture the result on each valid sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_sample <= gained;
        end
    end

    // Zero-run detector, present only when enabled
    if (ZDET_EN != 0) begin : g_zdet
        zero_run_detect #(
            .SAMPLE_W (SAMPLE_W),
            .RUN_LEN  (ZRUN_LEN)
        ) u_zdet (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (in_valid),
            .in_sample (in_sample),
            .zmute     (zero_mute)
        );
    end else begin : g_nozdet
        assign zero_mute = 1'b0;
    end

    // R1: valid follows the strobe by one cycle
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R4: muted samples come out silent
    a_r4_mute_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mute) |=> (out_sample == '0));

    // R6: the result holds between strobes
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_sample));

    // R7: code 0 is an exact passthrough
    a_r7_unity: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mute && gain_code == '0) |=> (out_sample == $past(in_sample)));

    // R5: boosting negative full scale by any nonzero step clips to negative full scale
    a_r5_neg_clip: assert property (@(posedge clk) disable iff (!rst_n)
        (CUT_MODE == 0 && in_valid && !mute && gain_code != '0 && in_sample == NEG_FS)
        |=> (out_sample == NEG_FS));

endmodule

// File: tb/audio_step_gain_tb.sv
// Bench: both flavours on one stimulus, compared every clock with a
// real-number model of the gain law, mute, clipping and zero-run detector.
module audio_step_gain_tb;
    localparam int ZL = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic        mute = 1'b0;
    logic [4:0]  code_c = '0;
    logic [3:0]  code_b = '0;
    logic        ov_c, ov_b, zm_c, zm_b;
    logic [15:0] os_c, os_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    bit    e_v;
    int    e_c, e_b, zc;
    bit    e_zm;
    int    tol_c, tol_b;
    string tag_c, tag_b, tag_z;

    always #4 clk = ~clk;

    audio_step_gain #(.CUT_MODE(1), .ZDET_EN(1), .ZRUN_LEN(ZL)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .gain_code(code_c), .mute(mute), .out_valid(ov_c), .out_sample(os_c),
        .zero_mute(zm_c));

    audio_step_gain #(.CUT_MODE(0), .ZDET_EN(0)) u_dut_rec (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .gain_code(code_b), .mute(mute), .out_valid(ov_b), .out_sample(os_b),
        .zero_mute(zm_b));

    function automatic int law(input int x, input int k, input bit cut);
        real g, y;
        g = 10.0 ** ((cut ? -1.0 : 1.0) * real'(k) * 1.5 / 20.0);
        y = $floor(real'(x) * g + 0.5);
        if (y > 32767.0) return 32767;
        if (y < -32768.0) return -32768;
        return $rtoi(y);
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp, input int tol);
        checks++;
        if (act - exp > tol || exp - act > tol) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R1", "cut valid", int'(ov_c), int'(e_v), 0);
        chk("R1", "boost valid", int'(ov_b), int'(e_v), 0);
        chk(tag_c, "cut sample", int'($signed(os_c)), e_c, tol_c);
        chk(tag_b, "boost sample", int'($signed(os_b)), e_b, tol_b);
        chk(tag_z, "zero flag", int'(zm_c), int'(e_zm), 0);
        chk("R11", "boost zero flag", int'(zm_b), 0, 0);
    endtask

    // Drive one cycle at a falling edge, update the model, compare one cycle later
    task automatic step(input bit v, input int x, input bit m, input int k);
        in_valid  = v;
        in_sample = 16'(x);
        mute      = m;
        code_c    = 5'(k);
        code_b    = 4'(k % 16);
        e_v       = v;
        if (v) begin
            if (m)           begin e_c = 0; tol_c = 0; tag_c = "R4"; end
            else if (k == 0) begin e_c = x; tol_c = 0; tag_c = "R7"; end
            else             begin e_c = law(x, k, 1'b1); tol_c = 1; tag_c = "R3"; end
            if (m)                begin e_b = 0; tol_b = 0; tag_b = "R4"; end
            else if (k % 16 == 0) begin e_b = x; tol_b = 0; tag_b = "R7"; end
            else begin
                e_b = law(x, k % 16, 1'b0); tol_b = 1;
                tag_b = (e_b == 32767 || e_b == -32768) ? "R5" : "R2";
            end
            if (x == 0) begin
                if (zc < ZL) zc++;
                e_zm = (zc >= ZL); tag_z = "R8";
            end else begin
                zc = 0; e_zm = 1'b0; tag_z = "R9";
            end
        end else begin
            tag_c = "R6"; tag_b = "R6"; tag_z = "R6";
        end
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        int pats[8] = '{12345, -20000, 32767, -32768, 1, -1, 1000, -3};
        e_v = 0; e_c = 0; e_b = 0; zc = 0; e_zm = 0; tol_c = 0; tol_b = 0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "valid", int'(ov_c) + int'(ov_b), 0, 0);
        chk("R10", "samples", int'(os_c) + int'(os_b), 0, 0);
        chk("R10", "zero flag", int'(zm_c), 0, 0);
        rst_n = 1'b1;
        tag_c = "R10"; tag_b = "R10"; tag_z = "R10";
        // R2 R3 R5 R7: every code against the law with varied samples
        for (int k = 0; k < 32; k++) begin
            for (int p = 0; p < 8; p++) step(1'b1, pats[p], 1'b0, k);
        end
        // R6: idle gaps hold the last result
        step(1'b1, 23456, 1'b0, 3);
        step(1'b0, 111, 1'b0, 9);
        step(1'b0, -111, 1'b1, 0);
        // R4: mute at several codes and samples
        for (int k = 0; k < 32; k += 5) step(1'b1, pats[k % 8], 1'b1, k);
        // R1: alternate strobes
        for (int i = 0; i < 6; i++) step(i % 2 == 0, 500 + i, 1'b0, 7);
        // R8: long zero run with idle cycles inside it
        for (int i = 0; i < ZL + 4; i++) begin
            step(1'b1, 0, 1'b0, 2);
            if (i == 5) step(1'b0, 77, 1'b0, 2);
        end
        step(1'b0, 0, 1'b0, 2);
        // R9: release on a nonzero sample, then a run one short
        step(1'b1, -5, 1'b0, 0);
        for (int i = 0; i < ZL - 1; i++) step(1'b1, 0, 1'b0, 1);
        step(1'b1, 9, 1'b0, 1);
        for (int i = 0; i < ZL; i++) step(1'b1, 0, 1'b1, 4);
        step(1'b1, 1, 1'b0, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule